// File: doc/BRIEF.md
# Per-Pixel Shading Correction Divider

This block flattens uneven illumination and uneven sensor response along a scan line. It divides every incoming 8-bit pixel by a white level that was stored for that same position along the line. On a calibration line, the block does not correct the pixels. It writes each one into a line memory as the white level for its position. On every later line, each pixel is scaled so that a pixel equal to its white level comes out at full scale.

A weak white level leaves fewer trustworthy bits in the quotient, so the precision of the result shrinks in steps as the stored level falls:

- The unreliable low bits are forced to zero.
- A two-bit tag on the output says how many bits are valid.
- A white level too weak to divide by is refused: the pixel is forced to white and an error flag is raised with it.

The divider is sequential and handles one pixel at a time. This fits a pixel clock that is a fraction of the system clock.

Top module: `shd_correct`

## Requirements
- R1: A one-cycle pulse on `cal_i` arms calibration. The next line that begins after the pulse (its first pixel carries `line_start_i`) is written into the reference memory, one entry per position. No output pixel is produced for any pixel of that line.
- R2: For a pixel `p` below its reference `r` (r ≥ 16), the output is floor(p·255 / r) with the low bits masked per R4–R6.
- R3: A pixel greater than or equal to its reference (r ≥ 16) yields every valid bit set (0xFC, 0xF8 or 0xF0 by band) and never wraps to a small value.
- R4: A reference of 64..255 gives tag 0 (six valid bits), and output bits [1:0] are zero.
- R5: A reference of 32..63 gives tag 1 (five valid bits), and output bits [2:0] are zero.
- R6: A reference of 16..31 gives tag 2 (four valid bits), and output bits [3:0] are zero.
- R7: A reference below 16 gives output 0xFF, tag 3 and `ref_err_o` high in the same cycle. `ref_err_o` is low on every other cycle.
- R8: Each accepted pixel produces exactly one `out_valid_o` pulse, one cycle wide, visible after the tenth rising edge following the edge that sampled the pixel.
- R9: The reference used for a pixel is the one stored at its position, counted from 0 at the pixel carrying `line_start_i`.
- R10: While reset is asserted, `out_valid_o`, `ref_err_o` and `out_pix_o` are zero.
- R11: A calibration pulse arriving in the middle of a line does not alter the rest of that line. Those pixels are still corrected against the old references.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_i | input | 8 | Incoming pixel sample |
| pix_valid_i | input | 1 | Pixel sample valid for one cycle |
| line_start_i | input | 1 | Marks the first pixel of a line (qualified by valid) |
| cal_i | input | 1 | Arms calibration of the next line |
| out_pix_o | output | 8 | Corrected, precision-masked pixel |
| out_valid_o | output | 1 | Corrected pixel valid for one cycle |
| prec_tag_o | output | 2 | 0: six bits, 1: five bits, 2: four bits, 3: clamped |
| ref_err_o | output | 1 | Reference too weak, output forced to white |

## Verification
The properties assume that pixels arrive at least ten clock cycles apart. This spacing lets the one-pulse-per-pixel and single-cycle output checks hold without a ready signal. They also assume lines no longer than the memory depth.

The stimulus sends each pixel and then waits thirteen cycles before the next one, and every line fits the reduced memory depth used by the bench. The sweep gives each of sixteen stored references, chosen to cover all four bands and their edges, every 8-bit pixel value exactly once.

// File: rtl/shd_pkg.sv
package shd_pkg;
  typedef enum logic [1:0] {
    PREC6      = 2'd0,
    PREC5      = 2'd1,
    PREC4      = 2'd2,
    PREC_CLAMP = 2'd3
  } prec_e;
endpackage

// File: rtl/shd_ref_line.sv
// Single-port reference line store with registered read.
module shd_ref_line #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [PIX_W-1:0] wdata_i,
  output logic [PIX_W-1:0] rdata_o
);
  logic [PIX_W-1:0] mem [DEPTH];
  logic [PIX_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[addr_i] <= wdata_i;
    end
    if (re_i) begin
      rdata_q <= mem[addr_i];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/shd_seq_div.sv
// Restoring divider, one quotient bit per cycle. Requires num[2W-1:W] < den
// for an exact result; the caller overrides other cases.
module shd_seq_div #(
  parameter int PIX_W = 8,
  localparam int DW   = 2 * PIX_W,
  localparam int CW   = $clog2(PIX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DW-1:0]    num_i,
  input  logic [PIX_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PIX_W-1:0] quot_o
);
  localparam logic [CW-1:0] LAST = CW'(PIX_W - 1);

  logic [PIX_W-1:0] rem_q, rem_n;
  logic [PIX_W-1:0] q_q, q_n;
  logic [PIX_W-1:0] den_q, den_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             busy_q, busy_n;
  logic             done_q, done_n;

  logic [PIX_W:0]   trial;
  logic [PIX_W:0]   diff;
  logic             fits;

  always_comb begin
    trial = {rem_q, q_q[PIX_W-1]};
    diff  = trial - {1'b0, den_q};
    fits  = (trial >= {1'b0, den_q});
  end

  always_comb begin
    rem_n  = rem_q;
    q_n    = q_q;
    den_n  = den_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (busy_q) begin
      rem_n = fits ? diff[PIX_W-1:0] : trial[PIX_W-1:0];
      q_n   = {q_q[PIX_W-2:0], fits};
      cnt_n = cnt_q + CW'(1);
      if (cnt_q == LAST) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end else if (start_i) begin
      rem_n  = num_i[DW-1:PIX_W];
      q_n    = num_i[PIX_W-1:0];
      den_n  = den_i;
      cnt_n  = '0;
      busy_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      q_q    <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      q_q    <= q_n;
      den_q  <= den_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = q_q;
endmodule

// File: rtl/shd_band.sv
// Classifies a reference level into a precision band and its output mask.
module shd_band #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] ref_i,
  output shd_pkg::prec_e   tag_o,
  output logic [PIX_W-1:0] mask_o
);
  localparam logic [PIX_W-1:0] ONE   = {{(PIX_W-1){1'b0}}, 1'b1};
  localparam logic [PIX_W-1:0] LIM6  = ONE << (PIX_W - 2);
  localparam logic [PIX_W-1:0] LIM5  = ONE << (PIX_W - 3);
  localparam logic [PIX_W-1:0] LIM4  = ONE << (PIX_W - 4);
  localparam logic [PIX_W-1:0] ALL1  = {PIX_W{1'b1}};
  localparam logic [PIX_W-1:0] MASK6 = ALL1 << (PIX_W - 6);
  localparam logic [PIX_W-1:0] MASK5 = ALL1 << (PIX_W - 5);
  localparam logic [PIX_W-1:0] MASK4 = ALL1 << (PIX_W - 4);

  always_comb begin
    if (ref_i >= LIM6) begin
      tag_o  = shd_pkg::PREC6;
      mask_o = MASK6;
    end else if (ref_i >= LIM5) begin
      tag_o  = shd_pkg::PREC5;
      mask_o = MASK5;
    end else if (ref_i >= LIM4) begin
      tag_o  = shd_pkg::PREC4;
      mask_o = MASK4;
    end else begin
      tag_o  = shd_pkg::PREC_CLAMP;
      mask_o = ALL1;
    end
  end
endmodule

// File: rtl/shd_correct.sv
// Per-position shading correction: calibration capture and divide-by-reference.
module shd_correct #(
  parameter int PIX_W    = 8,
  parameter int LINE_MAX = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_valid_i,
  input  logic             line_start_i,
  input  logic             cal_i,
  output logic [PIX_W-1:0] out_pix_o,
  output logic             out_valid_o,
  output logic [1:0]       prec_tag_o,
  output logic             ref_err_o
);
  localparam int AW = $clog2(LINE_MAX);
  localparam int DW = 2 * PIX_W;
  localparam logic [PIX_W-1:0] ALL1 = {PIX_W{1'b1}};

  // reset synchronizer
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // line position and calibration control
  logic [AW-1:0]    pos_q, pos_n;
  logic             pend_q, pend_n;
  logic             cal_line_q, cal_line_n;
  logic             fetch_q, fetch_n;
  logic [PIX_W-1:0] pix_q, pix_n;
  logic [PIX_W-1:0] ref_q, ref_n;
  logic [PIX_W-1:0] opix_q, opix_n;
  logic             ovld_q, ovld_n;
  logic [1:0]       otag_q, otag_n;
  logic             oerr_q, oerr_n;

  logic [AW-1:0]    idx;
  logic             cal_now;
  logic             cap_en;
  logic             take_en;
  logic [PIX_W-1:0] ref_rd;
  logic             div_busy;
  logic             div_done;
  logic [PIX_W-1:0] div_quot;
  logic [DW-1:0]    num;
  shd_pkg::prec_e   band_tag;
  logic [PIX_W-1:0] band_mask;

  always_comb begin
    idx     = line_start_i ? '0 : pos_q;
    cal_now = line_start_i ? pend_q : cal_line_q;
    cap_en  = pix_valid_i && cal_now;
    take_en = pix_valid_i && !cal_now && !fetch_q && !div_busy;
    num     = DW'(pix_q) * DW'(ALL1);
  end

  always_comb begin
    pos_n      = pos_q;
    pend_n     = pend_q | cal_i;
    cal_line_n = cal_line_q;
    if (pix_valid_i) begin
      pos_n = idx + AW'(1);
      if (line_start_i) begin
        cal_line_n = pend_q;
        pend_n     = cal_i;
      end
    end
  end

  always_comb begin
    fetch_n = take_en;
    pix_n   = take_en ? pix_i : pix_q;
    ref_n   = fetch_q ? ref_rd : ref_q;
  end

  always_comb begin
    opix_n = opix_q;
    otag_n = otag_q;
    ovld_n = div_done;
    oerr_n = 1'b0;
    if (div_done) begin
      otag_n = band_tag;
      if (band_tag == shd_pkg::PREC_CLAMP) begin
        opix_n = ALL1;
        oerr_n = 1'b1;
      end else if (pix_q >= ref_q) begin
        opix_n = band_mask;
      end else begin
        opix_n = div_quot & band_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      pos_q      <= '0;
      pend_q     <= 1'b0;
      cal_line_q <= 1'b0;
      fetch_q    <= 1'b0;
      pix_q      <= '0;
      ref_q      <= '0;
    end else begin
      pos_q      <= pos_n;
      pend_q     <= pend_n;
      cal_line_q <= cal_line_n;
      fetch_q    <= fetch_n;
      pix_q      <= pix_n;
      ref_q      <= ref_n;
    end
  end

  // output registers cleared directly by the external reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opix_q <= '0;
      ovld_q <= 1'b0;
      otag_q <= '0;
      oerr_q <= 1'b0;
    end else if (rst_sync_q) begin
      opix_q <= opix_n;
      ovld_q <= ovld_n;
      otag_q <= otag_n;
      oerr_q <= oerr_n;
    end
  end

  shd_ref_line #(.PIX_W(PIX_W), .DEPTH(LINE_MAX)) u_mem (
    .clk     (clk),
    .we_i    (cap_en),
    .re_i    (take_en),
    .addr_i  (idx),
    .wdata_i (pix_i),
    .rdata_o (ref_rd)
  );

  shd_seq_div #(.PIX_W(PIX_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .start_i (fetch_q),
    .num_i   (num),
    .den_i   (ref_rd),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quot_o  (div_quot)
  );

  shd_band #(.PIX_W(PIX_W)) u_band (
    .ref_i  (ref_q),
    .tag_o  (band_tag),
    .mask_o (band_mask)
  );

  assign out_pix_o   = opix_q;
  assign out_valid_o = ovld_q;
  assign prec_tag_o  = otag_q;
  assign ref_err_o   = oerr_q;
endmodule

// File: rtl/shd_correct_chk.sv
module shd_correct_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_valid_i,
  input logic [PIX_W-1:0] out_pix_o,
  input logic             out_valid_o,
  input logic [1:0]       prec_tag_o,
  input logic             ref_err_o
);
  localparam logic [PIX_W-1:0] ALL1 = {PIX_W{1'b1}};

  assert_clamp_white_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && prec_tag_o == 2'd3) |-> (out_pix_o == ALL1 && ref_err_o));

  assert_err_only_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_err_o |-> (out_valid_o && prec_tag_o == 2'd3));

  assert_mask_six_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && prec_tag_o == 2'd0) |-> (out_pix_o[1:0] == 2'b00));

  assert_mask_five_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && prec_tag_o == 2'd1) |-> (out_pix_o[2:0] == 3'b000));

  assert_mask_four_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && prec_tag_o == 2'd2) |-> (out_pix_o[3:0] == 4'b0000));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> !out_valid_o);

  assert_input_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_i |=> !pix_valid_i);

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R10: assert (!out_valid_o && !ref_err_o && out_pix_o == '0);
    end
  end
endmodule

bind shd_correct shd_correct_chk #(.PIX_W(PIX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pix_valid_i (pix_valid_i),
  .out_pix_o   (out_pix_o),
  .out_valid_o (out_valid_o),
  .prec_tag_o  (prec_tag_o),
  .ref_err_o   (ref_err_o)
);

// File: tb/shd_correct_tb.sv
module shd_correct_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINE = 16;

  logic       clk;
  logic       rst_n;
  logic [7:0] pix_i;
  logic       pix_valid_i;
  logic       line_start_i;
  logic       cal_i;
  logic [7:0] out_pix_o;
  logic       out_valid_o;
  logic [1:0] prec_tag_o;
  logic       ref_err_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] refs  [LINE];
  logic [7:0] refs2 [LINE];

  shd_correct #(.PIX_W(8), .LINE_MAX(LINE)) u_dut (
    .clk, .rst_n, .pix_i, .pix_valid_i, .line_start_i, .cal_i,
    .out_pix_o, .out_valid_o, .prec_tag_o, .ref_err_o
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int band_of(input int r);
    if (r >= 64) return 0;
    if (r >= 32) return 1;
    if (r >= 16) return 2;
    return 3;
  endfunction

  function automatic int exp_pix(input int p, input int r);
    int mask;
    case (band_of(r))
      0: mask = 8'hFC;
      1: mask = 8'hF8;
      2: mask = 8'hF0;
      default: return 255;
    endcase
    if (p >= r) return mask;
    return ((p * 255) / r) & mask;
  endfunction

  // drive one pixel, then observe 12 cycles
  task automatic run_pixel(input int p, input bit ls, input bit calp,
                           input bit want, input int r);
    int got_at = -1;
    int opix = 0, otag = 0, oerr = 0;
    @(negedge clk);
    pix_i = 8'(p); pix_valid_i = 1'b1; line_start_i = ls; cal_i = calp;
    @(negedge clk);
    pix_valid_i = 1'b0; line_start_i = 1'b0; cal_i = 1'b0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (out_valid_o && got_at < 0) begin
        got_at = i; opix = out_pix_o; otag = prec_tag_o; oerr = ref_err_o;
      end
    end
    if (!want) begin
      chk(got_at < 0, "R1 no output on calibration line", got_at, -1);
    end else begin
      int b, e;
      string rq;
      b = band_of(r);
      e = exp_pix(p, r);
      chk(got_at == 10, "R8 latency", got_at, 10);
      if (b == 3) rq = "R7 clamp value";
      else if (p >= r) rq = "R3 saturate";
      else rq = "R2 R9 quotient";
      chk(opix == e, rq, opix, e);
      chk(otag == b, (b == 0) ? "R4 tag" : (b == 1) ? "R5 tag" :
                     (b == 2) ? "R6 tag" : "R7 tag", otag, b);
      chk(oerr == (b == 3), "R7 error flag", oerr, int'(b == 3));
    end
  endtask

  task automatic cal_pulse();
    @(negedge clk);
    cal_i = 1'b1;
    @(negedge clk);
    cal_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int vals [LINE] = '{255, 200, 128, 64, 63, 40, 32, 31, 20, 16, 15, 8, 0, 100, 90, 70};
    for (int i = 0; i < LINE; i++) begin
      refs[i]  = 8'(vals[i]);
      refs2[i] = 8'(vals[LINE-1-i]);
    end
    rst_n = 1'b0; pix_i = '0; pix_valid_i = 1'b0; line_start_i = 1'b0; cal_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid_o, "R10 valid in reset", out_valid_o, 0);
    chk(!ref_err_o, "R10 error in reset", ref_err_o, 0);
    chk(out_pix_o == 0, "R10 pixel in reset", out_pix_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: calibrate with refs
    cal_pulse();
    for (int i = 0; i < LINE; i++) run_pixel(refs[i], i == 0, 1'b0, 1'b0, 0);

    // sweep: every reference sees every pixel value (R2..R9)
    for (int l = 0; l < 256; l++) begin
      for (int i = 0; i < LINE; i++) begin
        int p = (l + i * 17) % 256;
        run_pixel(p, i == 0, 1'b0, 1'b1, refs[i]);
      end
    end

    // R11: calibration pulse mid-line, rest of line still corrected
    for (int i = 0; i < LINE; i++) begin
      run_pixel(200 - i, i == 0, i == 8, 1'b1, refs[i]);
    end

    // R1: next line becomes calibration with new references
    for (int i = 0; i < LINE; i++) run_pixel(refs2[i], i == 0, 1'b0, 1'b0, 0);

    // R9: correction now uses the new per-position references
    for (int l = 0; l < 4; l++) begin
      for (int i = 0; i < LINE; i++) begin
        run_pixel((l * 61 + i * 29) % 256, i == 0, 1'b0, 1'b1, refs2[i]);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule